// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

The block turns one character per handshake into an asynchronous serial frame on a single output line. Each frame has a low start bit, then 5 to 9 data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. The character length, the parity mode and the stop count are inputs. They are captured with the character when it is accepted, so the surrounding logic may change them while a frame is being sent. The receiving side of the link is set to the same format.

Bit timing comes from an external baud tick. Each bit lasts exactly 16 ticks, and the line changes only on a clock edge where the tick is high. The block raises `din_ready` throughout the final stop bit. A character accepted then starts its start bit at the end of that stop bit, with no idle time between the two frames. Dropping `en` forces the line high at once and discards the frame in progress.

Top module: `uart_frame_tx`

## Requirements
- R1: A frame begins with a start bit at 0, followed by the data bits from `din[0]` upward. `len_sel` selects the character length: codes 0 to 4 give 5 to 9 bits, and codes 5 to 7 give 9 bits.
- R2: When `par_en`=1, a parity bit follows the last data bit. It is the XOR of the data bits inside the selected length, inverted when `par_odd`=1. Bits of `din` above the selected length affect neither the data nor the parity.
- R3: The frame ends with one stop bit at 1, or two when `stop2`=1.
- R4: Every bit lasts exactly 16 ticks. While `en`=1, `txd` changes only after a clock edge where `tick` was 1.
- R5: The data and all format inputs are captured on the accepting edge (`din_valid`=1 and `din_ready`=1). Changing them later does not alter that frame.
- R6: `din_ready` is 1 in idle and for the whole final stop bit while no character is pending. A character accepted in the final stop bit, including on its last edge, drives its start bit directly after that stop bit ends.
- R7: The idle line is 1. `busy` is 1 from acceptance until the last stop bit ends, and 0 when idle with nothing pending. A character accepted in idle starts on the next edge with `tick`=1.
- R8: During and after reset, `txd`=1, `busy`=0 and `din_ready`=1.
- R9: With `en`=0, `txd` is 1 in the same cycle and the frame in progress is dropped. `busy` falls on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Transmitter enable |
| len_sel | input | 3 | Character length code (bits = code + 5, at most 9) |
| par_en | input | 1 | Parity bit inserted when 1 |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| stop2 | input | 1 | Two stop bits when 1 |
| tick | input | 1 | Baud tick, one clock wide, 16 per bit |
| din | input | 9 | Character to send |
| din_valid | input | 1 | Character offered |
| din_ready | output | 1 | Character can be accepted |
| txd | output | 1 | Serial line |
| busy | output | 1 | Frame in progress or pending |

## Verification
The acceptance of the next character and the end of the final stop bit can fall on the same clock edge. In that case the state machine must both load the new character and select a start bit rather than idle. The bench provokes this by holding off `din_valid` and counting ticks until the 16th tick of the final stop bit, so the transfer lands on the ending edge. The scoreboard then requires the line to be low right after that edge, and it checks every bit of the new frame at 16-tick spacing.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int DW   = 9,
  parameter int MINW = 5,
  parameter int OSR  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [2:0]    len_sel,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          stop2,
  input  logic          tick,
  input  logic [DW-1:0] din,
  input  logic          din_valid,
  output logic          din_ready,
  output logic          txd,
  output logic          busy
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DW + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx, nbits, len_n;
  logic [DW-1:0] sh, msk;
  logic          pe, pb, s2, sidx, pend, line;

  wire acc       = din_valid & din_ready;
  wire bit_end   = tick & (cnt == CW'(OSR - 1));
  wire last_stop = (st == S_STOP) & (pend | (sidx == s2));

  always_comb begin
    if (int'(len_sel) >= DW - MINW) len_n = BW'(DW);
    else len_n = BW'(len_sel) + BW'(MINW);
    for (int i = 0; i < DW; i++) msk[i] = (i < int'(len_n));
  end

  wire pnew = par_odd ^ (^(din & msk));

  always_comb begin
    case (st)
      S_START: line = 1'b0;
      S_DATA:  line = sh[0];
      S_PAR:   line = pb;
      default: line = 1'b1;
    endcase
  end

  assign txd       = ~en | line;
  assign busy      = (st != S_IDLE) | pend;
  assign din_ready = ~pend & ((st == S_IDLE) | last_stop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bidx <= '0; nbits <= '0; sh <= '0;
      pe <= 1'b0; pb <= 1'b0; s2 <= 1'b0; sidx <= 1'b0; pend <= 1'b0;
    end else begin
      if (acc) begin
        sh <= din; nbits <= len_n; pe <= par_en; pb <= pnew; s2 <= stop2;
        pend <= 1'b1;
      end
      if (!en) begin
        st <= S_IDLE;
        cnt <= '0;
      end else if (st == S_IDLE) begin
        if (tick & (pend | acc)) begin
          st <= S_START; cnt <= '0; pend <= 1'b0;
        end
      end else if (tick) begin
        cnt <= bit_end ? '0 : cnt + 1'b1;
        if (bit_end) begin
          case (st)
            S_START: begin st <= S_DATA; bidx <= '0; end
            S_DATA: begin
              sh <= sh >> 1;
              if (bidx == nbits - 1'b1) begin
                st <= pe ? S_PAR : S_STOP; sidx <= 1'b0;
              end else bidx <= bidx + 1'b1;
            end
            S_PAR: begin st <= S_STOP; sidx <= 1'b0; end
            S_STOP: begin
              if (!last_stop) sidx <= 1'b1;
              else if (pend | acc) begin st <= S_START; pend <= 1'b0; end
              else st <= S_IDLE;
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end
endmodule

module uart_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic tick,
  input logic din_valid,
  input logic din_ready,
  input logic txd,
  input logic busy
);
  // R4
  tick_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> (!en || $stable(txd)));
  // R7
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !busy) |-> txd);
  // R6
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (din_valid && din_ready) |=> busy);
  // R3
  stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $fell(busy)) |-> $past(txd));
  // R8
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> din_ready);
endmodule

bind uart_frame_tx uart_frame_tx_chk i_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .din_valid(din_valid),
  .din_ready(din_ready), .txd(txd), .busy(busy)
);

// File: tb/test_uart_frame_tx.sv
`timescale 1ns/100ps
module test_uart_frame_tx;
  logic clk = 0, rst_n = 0, en = 1, par_en = 0, par_odd = 0, stop2 = 0;
  logic tick = 0, din_valid = 0, abort = 0;
  logic [2:0] len_sel = 0;
  logic [8:0] din = 0;
  logic din_ready, txd, busy;

  uart_frame_tx i_uart_frame_tx (
    .clk(clk), .rst_n(rst_n), .en(en), .len_sel(len_sel), .par_en(par_en),
    .par_odd(par_odd), .stop2(stop2), .tick(tick), .din(din),
    .din_valid(din_valid), .din_ready(din_ready), .txd(txd), .busy(busy)
  );

  always #2 clk = ~clk;

  int tdiv = 0;
  always @(posedge clk) begin
    #0.5;
    tdiv = (tdiv + 1) % 4;
    tick = (tdiv == 0);
  end

  typedef struct {
    logic [12:0] bits;
    int n;
    int nd;
    bit pe;
    string tag;
  } fr_t;
  fr_t q[$];

  int nchk = 0, nerr = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic fr_t mk(logic [8:0] d, int lc, bit pe, bit po, bit s2, string tag);
    fr_t f;
    int idx;
    bit p;
    f.bits = '1;
    f.nd = (lc >= 4) ? 9 : lc + 5;
    f.pe = pe;
    f.tag = tag;
    f.bits[0] = 1'b0;
    p = po;
    for (int i = 0; i < f.nd; i++) begin
      f.bits[1 + i] = d[i];
      p ^= d[i];
    end
    idx = f.nd + 1;
    if (pe) begin f.bits[idx] = p; idx++; end
    f.bits[idx] = 1'b1; idx++;
    if (s2) begin f.bits[idx] = 1'b1; idx++; end
    f.n = idx;
    return f;
  endfunction

  function automatic string lab(fr_t f, int k);
    if (k <= f.nd) return "R1";
    if (f.pe && k == f.nd + 1) return "R2";
    return "R3";
  endfunction

  fr_t cur;
  bit inframe = 0, bbad = 0, fbad = 0, tbad = 0, bsybad = 0, tprev = 0;
  logic prevtxd = 1;
  int k = 0, tc = 0;

  always @(negedge clk) begin
    if (!rst_n || abort) begin
      inframe = 0;
      tbad = 0;
    end else begin
      if (txd !== prevtxd && !tprev) tbad = 1;
      if (inframe && tprev) begin
        tc++;
        if (tc == 16) begin
          check(!bbad, lab(cur, k), $sformatf("bit %0d of %s", k, cur.tag),
                !cur.bits[k], cur.bits[k]);
          k++; tc = 0; bbad = 0;
          if (k == cur.n) begin
            inframe = 0;
            check(!fbad, "R5", {"captured format of ", cur.tag}, fbad, 0);
            check(!tbad, "R4", {"tick-aligned timing of ", cur.tag}, tbad, 0);
            check(!bsybad, "R7", {"busy during ", cur.tag}, bsybad, 0);
            tbad = 0;
            if (q.size() > 0)
              check(txd == 1'b0, "R6", {"no gap before ", q[0].tag}, txd, 0);
          end
        end
      end
      if (!inframe && txd == 1'b0) begin
        if (q.size() == 0) begin
          check(0, "R7", "unexpected start bit", txd, 1);
          cur = mk(9'h1FF, 4, 0, 0, 0, "unexpected");
        end else cur = q.pop_front();
        if (!tprev) tbad = 1;
        inframe = 1; k = 0; tc = 0; bbad = 0; fbad = 0; bsybad = 0;
      end
      if (inframe) begin
        if (txd !== cur.bits[k]) begin bbad = 1; fbad = 1; end
        if (busy !== 1'b1) bsybad = 1;
      end
    end
    prevtxd = txd;
    tprev = tick;
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic send(logic [8:0] d, int lc, bit pe, bit po, bit s2, string tag, bit late = 0);
    while (!din_ready) step();
    if (late) begin
      int c = 0;
      forever begin
        if (tick) c++;
        if (c == 16) break;
        step();
      end
    end
    din = d; len_sel = 3'(lc); par_en = pe; par_odd = po; stop2 = s2;
    din_valid = 1;
    q.push_back(mk(d, lc, pe, po, s2, tag));
    step();
    din_valid = 0;
    din = ~d; len_sel = ~3'(lc); par_en = ~pe; par_odd = ~po; stop2 = ~s2;
  endtask

  task automatic drain();
    while (q.size() != 0 || inframe) step();
    repeat (70) step();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired act=%0d exp=%0d", q.size(), 0);
    finish_run();
  end

  initial begin
    bit stay;
    repeat (3) @(negedge clk);
    check(txd == 1'b1, "R8", "txd in reset", txd, 1);
    check(busy == 1'b0, "R8", "busy in reset", busy, 0);
    check(din_ready == 1'b1, "R8", "ready in reset", din_ready, 1);
    @(posedge clk); #1 rst_n = 1;
    repeat (4) step();
    check(txd == 1'b1 && busy == 1'b0 && din_ready == 1'b1, "R8", "state after reset",
          {txd, busy, din_ready}, 3'b101);

    send(9'h0A5, 3, 0, 0, 0, "8N1 R1");
    drain();
    send(9'h1F3, 0, 1, 0, 0, "5E1 upper bits ignored R2");
    send(9'h1C3, 4, 1, 1, 1, "9O2 back-to-back R6");
    send(9'h055, 2, 1, 1, 0, "7O1");
    send(9'h02A, 1, 1, 0, 1, "6E2 R3");
    send(9'h1FF, 7, 0, 0, 1, "code7 9N2 R1");
    send(9'h100, 4, 1, 0, 0, "same-edge accept R6", 1);
    send(9'h000, 0, 1, 1, 0, "5O1 zero");
    drain();
    check(busy == 1'b0, "R7", "busy after drain", busy, 0);
    check(txd == 1'b1, "R7", "idle line", txd, 1);
    check(din_ready == 1'b1, "R6", "ready in idle", din_ready, 1);

    send(9'h0F0, 3, 0, 0, 0, "to be dropped");
    repeat (200) step();
    abort = 1; en = 0;
    q.delete();
    @(negedge clk);
    check(txd == 1'b1, "R9", "line high when disabled", txd, 1);
    @(negedge clk);
    check(busy == 1'b0, "R9", "busy after disable", busy, 0);
    stay = 1;
    repeat (100) begin
      @(negedge clk);
      if (txd !== 1'b1) stay = 0;
    end
    check(stay, "R9", "line stays idle while disabled", stay, 1);
    step();
    en = 1;
    step();
    abort = 0;
    repeat (8) step();
    send(9'h13C, 4, 1, 0, 1, "recover after R9");
    drain();
    finish_run();
  end
endmodule